// File: doc/BRIEF.md
# ECC Error Capture Unit for Split 128-bit Flash Words

This block sits behind a SEC-DED decoder that checks each 128-bit flash word as two separate 64-bit halves. For every checked access the decoder reports, per half, whether a correctable single-bit error or an uncorrectable error was seen, which polarity the flipped bit had, whether it sat in the check bits or the data bits, and its bit index. The unit records sticky status per half. It captures the 64-bit-aligned address of the first single-bit error and of the first uncorrectable error in each half, together with the type and position of that first single-bit error.

A saturating counter tallies single-bit errors against a programmable threshold, which limits how often single-bit interrupts fire. Uncorrectable errors raise their own interrupt flag at once. Software reaches every field through a small word-addressed register port with registered read data. All checking is gated by a 4-bit key field that must hold one specific value.

Top module: `ecc_err_capture`

## Requirements
- R1: After reset, the key field reads 0x5 (checking off), and the status, both interrupt flags, both interrupt pins, the counter and the threshold are all zero.
- R2: Events are recorded only while the key field (offset 0x0, bits 3:0) holds 0xA. With any other value, an event changes no status bit, counter, flag or captured field.
- R3: The status word (offset 0x1) holds the low half in bits 2:0 and the high half in bits 18:16. Within a half, bit 0 means a single-bit error whose flipped bit read 0, bit 1 means one that read 1, and bit 2 means an uncorrectable error. An uncorrectable error in a half suppresses a single-bit report for that same half in that access.
- R4: Writing ones to the clear register (offset 0x2, same layout as the status word) clears those status bits and leaves zero positions untouched. A new error in the same cycle wins over the clear. Offset 0x2 reads as zero.
- R5: A captured address is the access byte address with bits 3:0 replaced by {half, 000}, where half is 0 for the low half and 1 for the high half. Single-bit addresses are at offsets 0x8 (low) and 0x9 (high); uncorrectable addresses are at 0xA (low) and 0xB (high).
- R6: A half's single-bit address, type and position are captured only when that half's bits 1:0 are clear, and its uncorrectable address only when its bit 2 is clear. A clear written in the same cycle counts as already done.
- R7: The position register (offset 0x7) holds the low position in bits 5:0 and the low type in bit 8, and the high position in bits 21:16 and the high type in bit 24. A type of 1 means check bits and 0 means data bits.
- R8: Each half with a recorded single-bit error adds one to the counter (offset 0x3, writable). The counter never exceeds the threshold (offset 0x4) and holds there without wrapping, including at the all-ones boundary.
- R9: The flag register (offset 0x5) reads 1 for a single-bit interrupt and 2 for an uncorrectable one, and the pins irq_sbe and irq_ube mirror these bits. The single-bit flag sets whenever a single-bit error leaves the counter at the threshold. The uncorrectable flag sets on any recorded uncorrectable error. Writing ones to offset 0x6 clears the flags, and a same-cycle set wins.
- R10: Read data appears on the cycle after reg_rd is asserted. Offsets 0x2, 0x6 and unmapped offsets read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_valid | input | 1 | Decoder result valid for this access |
| ev_addr | input | 32 | Byte address of the 128-bit word |
| ev_sbe | input | 2 | Single-bit error per half (bit 0 low) |
| ev_ube | input | 2 | Uncorrectable error per half |
| ev_pol | input | 2 | Value the flipped bit read (1 = read as 1) |
| ev_chk | input | 2 | Error in check bits (1) or data bits (0) |
| ev_pos | input | 12 | Bit index per half, low half in bits 5:0 |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 4 | Register word offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| irq_sbe | output | 1 | Single-bit interrupt flag |
| irq_ube | output | 1 | Uncorrectable interrupt flag |

## Verification
The bench builds the unit with its default sizes: a 32-bit address and a 16-bit counter with a 6-bit position field. Because the threshold is a register, small values such as 3 bring counter saturation and repeated single-bit interrupts within a few events. Loading the counter with 0xFFFE under a threshold of 0xFFFF reaches the top of the 16-bit range, where a double-half event would carry past the width without the extra sum bit.

// File: rtl/ecc_cap_pkg.sv
package ecc_cap_pkg;
  localparam int POS_W  = 6;
  localparam int DATA_W = 32;
  localparam int REG_AW = 4;

  localparam logic [3:0] KEY_ON  = 4'hA;
  localparam logic [3:0] KEY_OFF = 4'h5;

  localparam logic [REG_AW-1:0] OFS_KEY     = 4'h0;
  localparam logic [REG_AW-1:0] OFS_STATUS  = 4'h1;
  localparam logic [REG_AW-1:0] OFS_STCLR   = 4'h2;
  localparam logic [REG_AW-1:0] OFS_COUNT   = 4'h3;
  localparam logic [REG_AW-1:0] OFS_THRESH  = 4'h4;
  localparam logic [REG_AW-1:0] OFS_FLAG    = 4'h5;
  localparam logic [REG_AW-1:0] OFS_FLCLR   = 4'h6;
  localparam logic [REG_AW-1:0] OFS_POS     = 4'h7;
  localparam logic [REG_AW-1:0] OFS_SADR_LO = 4'h8;
  localparam logic [REG_AW-1:0] OFS_SADR_HI = 4'h9;
  localparam logic [REG_AW-1:0] OFS_UADR_LO = 4'hA;
  localparam logic [REG_AW-1:0] OFS_UADR_HI = 4'hB;

  typedef struct packed {
    logic             sbe;
    logic             ube;
    logic             pol;
    logic             chk;
    logic [POS_W-1:0] pos;
  } half_ev_t;
endpackage

// File: rtl/ecc_half_capture.sv
module ecc_half_capture
  import ecc_cap_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int HALF_IDX = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              chk_en,
  input  logic              ev_valid,
  input  half_ev_t          ev,
  input  logic [ADDR_W-1:0] ev_addr,
  input  logic [2:0]        clr,
  output logic [2:0]        status,
  output logic [ADDR_W-1:0] sbe_addr,
  output logic [ADDR_W-1:0] ube_addr,
  output logic              err_chk,
  output logic [POS_W-1:0]  err_pos,
  output logic              sbe_hit
);
  logic              ube_hit;
  logic [1:0]        fail_left;
  logic              unc_left;
  logic [ADDR_W-1:0] aligned;

  assign ube_hit   = chk_en && ev_valid && ev.ube;
  assign sbe_hit   = chk_en && ev_valid && ev.sbe && !ev.ube;
  assign fail_left = status[1:0] & ~clr[1:0];
  assign unc_left  = status[2] & ~clr[2];
  assign aligned   = {ev_addr[ADDR_W-1:4], 1'(HALF_IDX), 3'b000};

  always_ff @(posedge clk) begin
    if (rst) begin
      status   <= '0;
      sbe_addr <= '0;
      ube_addr <= '0;
      err_chk  <= 1'b0;
      err_pos  <= '0;
    end else begin
      status <= (status & ~clr) | {ube_hit, sbe_hit & ev.pol, sbe_hit & ~ev.pol};
      if (sbe_hit && fail_left == 2'b00) begin
        sbe_addr <= aligned;
        err_chk  <= ev.chk;
        err_pos  <= ev.pos;
      end
      if (ube_hit && !unc_left) ube_addr <= aligned;
    end
  end

  AST_OFF_NO_SET: assert property (@(posedge clk) disable iff (rst)
    (!chk_en && clr == 3'b000) |=> $stable(status)); // R2
  AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (rst)
    (clr == 3'b000) |=> ((status & $past(status)) == $past(status))); // R4
  AST_SBE_ADDR_HOLD: assert property (@(posedge clk) disable iff (rst)
    ((status[1:0] & ~clr[1:0]) != 2'b00) |=> $stable(sbe_addr)); // R6
endmodule

// File: rtl/ecc_sbe_counter.sv
module ecc_sbe_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       inc_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] thr,
  output logic [CNT_W-1:0] count,
  output logic             hit
);
  logic [CNT_W:0] sum;
  logic           reach;

  assign sum   = {1'b0, count} + {{(CNT_W-1){1'b0}}, inc_n};
  assign reach = (inc_n != 2'd0) && (sum >= {1'b0, thr});
  assign hit   = reach && !load;

  always_ff @(posedge clk) begin
    if (rst)                  count <= '0;
    else if (load)            count <= load_val;
    else if (inc_n != 2'd0)   count <= reach ? thr : sum[CNT_W-1:0];
  end

  AST_CNT_SATURATES: assert property (@(posedge clk) disable iff (rst)
    (inc_n != 2'd0 && !load) |=> (count <= $past(thr))); // R8
endmodule

// File: rtl/ecc_err_capture.sv
module ecc_err_capture
  import ecc_cap_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ev_valid,
  input  logic [ADDR_W-1:0] ev_addr,
  input  logic [1:0]        ev_sbe,
  input  logic [1:0]        ev_ube,
  input  logic [1:0]        ev_pol,
  input  logic [1:0]        ev_chk,
  input  logic [2*POS_W-1:0] ev_pos,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq_sbe,
  output logic              irq_ube
);
  localparam int HALVES  = 2;
  localparam int HI_BASE = DATA_W / 2;

  logic [3:0]       key;
  logic             chk_en;
  logic [CNT_W-1:0] thr;
  logic [CNT_W-1:0] count;
  logic [1:0]       flag;
  logic             cnt_hit;
  logic [1:0]       flag_clr;

  logic [2:0]        st     [HALVES];
  logic [2:0]        st_clr [HALVES];
  logic [ADDR_W-1:0] s_adr  [HALVES];
  logic [ADDR_W-1:0] u_adr  [HALVES];
  logic [HALVES-1:0] h_chk;
  logic [POS_W-1:0]  h_pos  [HALVES];
  logic [HALVES-1:0] h_sbe;

  logic wr_key, wr_stclr, wr_cnt, wr_thr, wr_flclr;

  assign chk_en   = (key == KEY_ON);
  assign wr_key   = reg_wr && reg_addr == OFS_KEY;
  assign wr_stclr = reg_wr && reg_addr == OFS_STCLR;
  assign wr_cnt   = reg_wr && reg_addr == OFS_COUNT;
  assign wr_thr   = reg_wr && reg_addr == OFS_THRESH;
  assign wr_flclr = reg_wr && reg_addr == OFS_FLCLR;
  assign flag_clr = wr_flclr ? reg_wdata[1:0] : 2'b00;

  for (genvar h = 0; h < HALVES; h++) begin : g_half
    half_ev_t hev;
    assign hev.sbe = ev_sbe[h];
    assign hev.ube = ev_ube[h];
    assign hev.pol = ev_pol[h];
    assign hev.chk = ev_chk[h];
    assign hev.pos = ev_pos[h*POS_W +: POS_W];
    assign st_clr[h] = wr_stclr ? reg_wdata[h*HI_BASE +: 3] : 3'b000;

    ecc_half_capture #(.ADDR_W(ADDR_W), .HALF_IDX(h)) u_half (
      .clk      (clk),
      .rst      (rst),
      .chk_en   (chk_en),
      .ev_valid (ev_valid),
      .ev       (hev),
      .ev_addr  (ev_addr),
      .clr      (st_clr[h]),
      .status   (st[h]),
      .sbe_addr (s_adr[h]),
      .ube_addr (u_adr[h]),
      .err_chk  (h_chk[h]),
      .err_pos  (h_pos[h]),
      .sbe_hit  (h_sbe[h])
    );
  end

  ecc_sbe_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .inc_n    ({1'b0, h_sbe[0]} + {1'b0, h_sbe[1]}),
    .load     (wr_cnt),
    .load_val (reg_wdata[CNT_W-1:0]),
    .thr      (thr),
    .count    (count),
    .hit      (cnt_hit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      key  <= KEY_OFF;
      thr  <= '0;
      flag <= 2'b00;
    end else begin
      if (wr_key) key <= reg_wdata[3:0];
      if (wr_thr) thr <= reg_wdata[CNT_W-1:0];
      flag[0] <= (flag[0] & ~flag_clr[0]) | cnt_hit;
      flag[1] <= (flag[1] & ~flag_clr[1]) | (chk_en && ev_valid && ev_ube != 2'b00);
    end
  end

  assign irq_sbe = flag[0];
  assign irq_ube = flag[1];

  logic [DATA_W-1:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    unique case (reg_addr)
      OFS_KEY:     rd_mux[3:0] = key;
      OFS_STATUS: begin
        rd_mux[2:0]           = st[0];
        rd_mux[HI_BASE +: 3]  = st[1];
      end
      OFS_COUNT:   rd_mux[CNT_W-1:0] = count;
      OFS_THRESH:  rd_mux[CNT_W-1:0] = thr;
      OFS_FLAG:    rd_mux[1:0] = flag;
      OFS_POS: begin
        rd_mux[POS_W-1:0]         = h_pos[0];
        rd_mux[8]                 = h_chk[0];
        rd_mux[HI_BASE +: POS_W]  = h_pos[1];
        rd_mux[HI_BASE + 8]       = h_chk[1];
      end
      OFS_SADR_LO: rd_mux[ADDR_W-1:0] = s_adr[0];
      OFS_SADR_HI: rd_mux[ADDR_W-1:0] = s_adr[1];
      OFS_UADR_LO: rd_mux[ADDR_W-1:0] = u_adr[0];
      OFS_UADR_HI: rd_mux[ADDR_W-1:0] = u_adr[1];
      default:     rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= rd_mux;
  end

  AST_UBE_FLAG: assert property (@(posedge clk) disable iff (rst)
    (chk_en && ev_valid && ev_ube != 2'b00) |=> irq_ube); // R9
  AST_OFF_NO_FLAG: assert property (@(posedge clk) disable iff (rst)
    (!chk_en && flag_clr == 2'b00) |=> $stable(flag)); // R2
endmodule

// File: tb/sim_ecc_err_capture.sv
`timescale 1ns/1ps
module sim_ecc_err_capture;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ev_valid = 1'b0;
  logic [31:0] ev_addr = '0;
  logic [1:0]  ev_sbe = '0, ev_ube = '0, ev_pol = '0, ev_chk = '0;
  logic [11:0] ev_pos = '0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq_sbe, irq_ube;
  int nchk = 0, nfail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  ecc_err_capture u0 (.*);

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    nchk++;
    if (got !== exp) begin
      nfail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd_chk(input logic [3:0] a, input logic [31:0] exp, input string req);
    @(negedge clk); reg_rd = 1'b1; reg_addr = a;
    @(negedge clk); reg_rd = 1'b0;
    chk(req, reg_rdata, exp);
  endtask

  task automatic drive_ev(input logic [31:0] a, input logic [1:0] s, input logic [1:0] u,
                          input logic [1:0] p, input logic [1:0] c, input logic [11:0] pos);
    ev_valid = 1'b1; ev_addr = a; ev_sbe = s; ev_ube = u; ev_pol = p; ev_chk = c; ev_pos = pos;
  endtask

  task automatic ev(input logic [31:0] a, input logic [1:0] s, input logic [1:0] u,
                    input logic [1:0] p, input logic [1:0] c, input logic [11:0] pos);
    @(negedge clk); drive_ev(a, s, u, p, c, pos);
    @(negedge clk); ev_valid = 1'b0;
  endtask

  task automatic t_reset;
    rd_chk(4'h0, 32'h5, "R1 key");
    rd_chk(4'h1, 32'h0, "R1 status");
    rd_chk(4'h3, 32'h0, "R1 count");
    rd_chk(4'h4, 32'h0, "R1 thresh");
    rd_chk(4'h5, 32'h0, "R1 flags");
    chk("R1 pins", {30'b0, irq_ube, irq_sbe}, 32'h0);
  endtask

  task automatic t_disabled;
    ev(32'h100, 2'b01, 2'b10, 2'b00, 2'b00, 12'h0);
    rd_chk(4'h1, 32'h0, "R2 key 0x5 status");
    rd_chk(4'h3, 32'h0, "R2 key 0x5 count");
    wr(4'h0, 32'h3);
    ev(32'h100, 2'b11, 2'b00, 2'b00, 2'b00, 12'h0);
    rd_chk(4'h1, 32'h0, "R2 key 0x3 status");
    chk("R2 key 0x3 pins", {30'b0, irq_ube, irq_sbe}, 32'h0);
    wr(4'h0, 32'hA);
    rd_chk(4'h0, 32'hA, "R2 key readback");
  endtask

  task automatic t_status;
    wr(4'h4, 32'd100);
    ev(32'h1234, 2'b01, 2'b00, 2'b00, 2'b00, {6'd0, 6'd17});
    rd_chk(4'h1, 32'h1, "R3 low fail0");
    ev(32'h4567, 2'b10, 2'b00, 2'b10, 2'b10, {6'd5, 6'd0});
    rd_chk(4'h1, 32'h0002_0001, "R3 high fail1");
    rd_chk(4'h8, 32'h1230, "R5 sbe addr low");
    rd_chk(4'h9, 32'h4568, "R5 sbe addr high");
    rd_chk(4'h7, 32'h0105_0011, "R7 pos/type");
    rd_chk(4'h3, 32'd2, "R8 count 2");
  endtask

  task automatic t_hold;
    ev(32'h9990, 2'b01, 2'b00, 2'b01, 2'b01, {6'd0, 6'd3});
    rd_chk(4'h8, 32'h1230, "R6 addr held");
    rd_chk(4'h7, 32'h0105_0011, "R6 pos held");
    rd_chk(4'h1, 32'h0002_0003, "R3 both fail bits");
    wr(4'h2, 32'h3);
    rd_chk(4'h1, 32'h0002_0000, "R4 clear low only");
    ev(32'h9990, 2'b01, 2'b00, 2'b01, 2'b01, {6'd0, 6'd3});
    rd_chk(4'h8, 32'h9990, "R6 recapture");
    rd_chk(4'h7, 32'h0105_0103, "R7 recapture pos");
  endtask

  task automatic t_unc;
    ev(32'h7774, 2'b01, 2'b11, 2'b00, 2'b00, 12'h0);
    rd_chk(4'h1, 32'h0006_0006, "R3 unc precedence");
    rd_chk(4'h3, 32'd4, "R3 suppressed sbe not counted");
    rd_chk(4'hA, 32'h7770, "R5 ube addr low");
    rd_chk(4'hB, 32'h7778, "R5 ube addr high");
    rd_chk(4'h5, 32'h2, "R9 ube flag");
    chk("R9 pins", {30'b0, irq_ube, irq_sbe}, 32'h2);
    wr(4'h6, 32'h2);
    rd_chk(4'h5, 32'h0, "R9 ube flag clear");
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 4'h2; reg_wdata = 32'h4;
    drive_ev(32'h1110, 2'b00, 2'b01, 2'b00, 2'b00, 12'h0);
    @(negedge clk); reg_wr = 1'b0; ev_valid = 1'b0;
    rd_chk(4'h1, 32'h0006_0006, "R4 set wins over clear");
    rd_chk(4'hA, 32'h1110, "R6 capture after same-cycle clear");
    wr(4'h2, 32'h0007_0007);
    wr(4'h6, 32'h3);
    rd_chk(4'h1, 32'h0, "R4 clear all");
    rd_chk(4'h2, 32'h0, "R10 clear reg reads zero");
  endtask

  task automatic t_count;
    wr(4'h3, 32'h0);
    wr(4'h4, 32'd3);
    ev(32'h20, 2'b01, 2'b00, 2'b00, 2'b00, 12'h0);
    rd_chk(4'h3, 32'd1, "R8 count 1");
    rd_chk(4'h5, 32'h0, "R9 below threshold");
    ev(32'h20, 2'b11, 2'b00, 2'b00, 2'b00, 12'h0);
    rd_chk(4'h3, 32'd3, "R8 reach threshold");
    chk("R9 irq_sbe at threshold", {31'b0, irq_sbe}, 32'h1);
    wr(4'h6, 32'h1);
    rd_chk(4'h5, 32'h0, "R9 sbe flag clear");
    ev(32'h20, 2'b10, 2'b00, 2'b00, 2'b00, 12'h0);
    rd_chk(4'h3, 32'd3, "R8 holds at threshold");
    rd_chk(4'h5, 32'h1, "R9 refire at threshold");
    wr(4'h4, 32'hFFFF);
    wr(4'h3, 32'hFFFE);
    wr(4'h6, 32'h1);
    ev(32'h20, 2'b11, 2'b00, 2'b00, 2'b00, 12'h0);
    rd_chk(4'h3, 32'hFFFF, "R8 no wrap at all-ones");
    rd_chk(4'h5, 32'h1, "R9 flag at all-ones");
  endtask

  task automatic t_misc;
    rd_chk(4'hF, 32'h0, "R10 unmapped");
    rd_chk(4'h6, 32'h0, "R10 flag clear reads zero");
    wr(4'h0, 32'h5);
    wr(4'h2, 32'h0007_0007);
    wr(4'h6, 32'h3);
    ev(32'h40, 2'b00, 2'b11, 2'b00, 2'b00, 12'h0);
    rd_chk(4'h5, 32'h0, "R2 disabled no flag");
    rd_chk(4'h1, 32'h0, "R2 disabled no status");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset;
    t_disabled;
    t_status;
    t_hold;
    t_unc;
    t_count;
    t_misc;
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nchk++;
      nfail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end
endmodule